// File: doc/BRIEF.md
# Banked Private Peripheral Window Decoder

This block sits in front of a 4 KiB register window that up to four processor cores share. Each access brings an offset, read and write strobes, write data and the index of the core making it. The block sorts the access into one of three destinations. Small control registers live in the block itself. Each core has an interrupt-interface slot. Each core also has a timer/watchdog pair. For the two per-core windows there is a low alias range that always lands in the requesting core's bank, and a banked range where the offset names the core. The downstream interrupt interfaces and timers are not part of this block. They see only the one-hot select, the slot index, the local offset and the forwarded strobes and data.

Every access is resolved in one registered step. The cycle after a strobe, a small state machine presents exactly one outcome:
- **ST_IDLE**: no strobe was seen.
- **ST_ROUTE**: forwarded to a slot.
- **ST_LOCAL**: served by the built-in registers.
- **ST_MUTE**: aimed at a core beyond the configured count, so it reads zero and its write is dropped.
- **ST_FAULT**: unmapped, and the error output is raised for that cycle.

Transitions are taken on every clock edge. ST_IDLE is taken when neither strobe is high. Otherwise the decoded region and legality pick one of the other four states. Any state can follow any state.

Top module: `ppw_decoder`

## Requirements
- R1: Only `req_addr[11:0]` is decoded. Bits above 11 have no effect on any output.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_rd` or `req_wr` high, and is low otherwise. All other outputs are zero while `rsp_valid` is low.
- R3: The control register at local offset 0x00 stores only bit 0 of a write and resets to 0. It reads back as that bit with all other bits zero.
- R4: Offset 0x04 reads as the configuration word. Bit 4+i is set for each core i below `cpu_count`, and bits [1:0] hold `cpu_count`-1. All other bits are zero. For example, a count of 4 gives 0xF3 and a count of 2 gives 0x31.
- R5: Offsets 0x08 and 0x0C read as zero. A write to 0x0C is accepted without error and changes no state.
- R6: In the range below 0x100, any offset other than 0x00/0x04/0x08/0x0C is a fault, and so is a write to 0x04 or 0x08. A fault raises `rsp_err` for one cycle, with all selects low and `rsp_rdata` zero. No register changes.
- R7: Offsets 0x100–0x1FF raise `sel_intf`. `rsp_slot` is set to `req_cpu` and `rsp_loc` to offset[7:0].
- R8: Offsets 0x200–0x5FF raise `sel_intf`. `rsp_slot` is set to (offset−0x200)>>8 and `rsp_loc` to offset[7:0].
- R9: Offsets 0x600–0x6FF raise `sel_timer`. `rsp_slot` is set to 2·`req_cpu` + offset[5] (1 = watchdog), and `rsp_loc` to offset[3:0] zero-extended.
- R10: Offsets 0x700–0xAFF raise `sel_timer`. `rsp_slot` is set to 2·((offset−0x700)>>8) + offset[5], and `rsp_loc` to offset[3:0].
- R11: A per-core access whose core index is not below `cpu_count` is muted. `rsp_valid` is high, and no select, forwarded strobe or error is raised. `rsp_rdata` is zero.
- R12: Offsets 0xB00–0xFFF are faults, with the behaviour described in R6.
- R13: When both strobes are high on offset 0x00, the read returns the value held before the write, and the write is stored.
- R14: At most one of `sel_local`, `sel_intf`, `sel_timer` is high in any cycle. `rsp_rd`/`rsp_wr` copy the request strobes only when one of them is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_addr | input | 32 | Access offset, only [11:0] used |
| req_wdata | input | 32 | Write data |
| req_cpu | input | 2 | Index of the requesting core |
| cpu_count | input | 3 | Number of present cores, 1 to 4 |
| rsp_valid | output | 1 | Outcome of the previous cycle's access |
| rsp_rd | output | 1 | Forwarded read strobe |
| rsp_wr | output | 1 | Forwarded write strobe |
| rsp_wdata | output | 32 | Forwarded write data |
| sel_local | output | 1 | Built-in register block selected |
| sel_intf | output | 1 | Interrupt-interface slot selected |
| sel_timer | output | 1 | Timer/watchdog slot selected |
| rsp_slot | output | 3 | Slot index for the selected destination |
| rsp_loc | output | 8 | Local offset inside the slot |
| rsp_rdata | output | 32 | Read data from built-in registers |
| rsp_err | output | 1 | One-cycle fault pulse |

## Verification
A read and a write can land on the control register in the same cycle. The returned value and the stored value then come from different sides of one clock edge. The bench raises both strobes on offset 0x00 with the stored bit at 0 and write data of 1. It expects read data of 0 in the response, then a following plain read of 1. The mute and route decisions also meet in one cycle when the alias window is used by a core above the count. To provoke this, the bench lowers `cpu_count` and aliases from core 3. It judges the result by the absence of any select alongside a high `rsp_valid`.

// File: rtl/ppw_pkg.sv
package ppw_pkg;

    // Outcome held for one cycle after an access
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ROUTE = 3'd1,
        ST_LOCAL = 3'd2,
        ST_MUTE  = 3'd3,
        ST_FAULT = 3'd4
    } ppw_state_e;

    // Region of the window an offset falls in
    typedef enum logic [1:0] {
        RG_LOCAL = 2'd0,
        RG_INTF  = 2'd1,
        RG_TIMER = 2'd2,
        RG_NONE  = 2'd3
    } ppw_region_e;

    localparam int WIN_W = 12;

    // Window boundaries (behaviour depends on these)
    localparam logic [WIN_W-1:0] WIN_INTF_ALIAS = 12'h100;
    localparam logic [WIN_W-1:0] WIN_INTF_BANK  = 12'h200;
    localparam logic [WIN_W-1:0] WIN_TMR_ALIAS  = 12'h600;
    localparam logic [WIN_W-1:0] WIN_TMR_BANK   = 12'h700;
    localparam logic [WIN_W-1:0] WIN_END        = 12'hB00;

    // Built-in register offsets
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_CFG   = 8'h04;
    localparam logic [7:0] OFS_STAT  = 8'h08;
    localparam logic [7:0] OFS_FLUSH = 8'h0C;

    // First bit of the present-core mask in the configuration word
    localparam int CFG_MASK_LSB = 4;

endpackage

// File: rtl/ppw_window_decode.sv
module ppw_window_decode
    import ppw_pkg::*;
#(
    parameter int CPU_W  = 2,
    parameter int SLOT_W = CPU_W + 1,
    parameter int LOC_W  = 8
) (
    input  logic [WIN_W-1:0]  off,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [CPU_W:0]    cpu_count,
    output ppw_region_e       region,
    output logic              in_count,
    output logic [SLOT_W-1:0] slot,
    output logic [LOC_W-1:0]  loc
);

    localparam int PAGE_W = WIN_W - 8;
    localparam logic [PAGE_W-1:0] INTF_PAGE0 = WIN_INTF_BANK[WIN_W-1:8];
    localparam logic [PAGE_W-1:0] TMR_PAGE0  = WIN_TMR_BANK[WIN_W-1:8];

    logic [PAGE_W-1:0] page;
    logic [PAGE_W-1:0] bank;
    logic              wd_pick;

    assign page    = off[WIN_W-1:8];
    assign wd_pick = off[5];

    always_comb begin
        region = RG_NONE;
        bank   = '0;
        loc    = '0;
        if (off < WIN_INTF_ALIAS) begin
            region = RG_LOCAL;
            loc    = LOC_W'(off[7:0]);
        end else if (off < WIN_INTF_BANK) begin
            region = RG_INTF;
            bank   = PAGE_W'(req_cpu);
            loc    = LOC_W'(off[7:0]);
        end else if (off < WIN_TMR_ALIAS) begin
            region = RG_INTF;
            bank   = page - INTF_PAGE0;
            loc    = LOC_W'(off[7:0]);
        end else if (off < WIN_TMR_BANK) begin
            region = RG_TIMER;
            bank   = PAGE_W'(req_cpu);
            loc    = LOC_W'(off[3:0]);
        end else if (off < WIN_END) begin
            region = RG_TIMER;
            bank   = page - TMR_PAGE0;
            loc    = LOC_W'(off[3:0]);
        end
    end

    assign in_count = (int'(bank) < int'(cpu_count));

    always_comb begin
        unique case (region)
            RG_TIMER: slot = {bank[CPU_W-1:0], wd_pick};
            RG_INTF:  slot = SLOT_W'(bank[CPU_W-1:0]);
            default:  slot = '0;
        endcase
    end

endmodule

// File: rtl/ppw_ctrl_regs.sv
module ppw_ctrl_regs
    import ppw_pkg::*;
#(
    parameter int MAX_CPU = 4,
    parameter int CPU_W   = 2,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              rd,
    input  logic              wr,
    input  logic [7:0]        reg_off,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CPU_W:0]    cpu_count,
    output logic              legal,
    output logic [DATA_W-1:0] rdata
);

    logic              ctrl_q;
    logic              rd_ok;
    logic              wr_ok;
    logic              wr_en;
    logic [DATA_W-1:0] cfg_word;

    always_comb begin
        unique case (reg_off)
            OFS_CTRL, OFS_CFG, OFS_STAT, OFS_FLUSH: rd_ok = 1'b1;
            default:                                rd_ok = 1'b0;
        endcase
        unique case (reg_off)
            OFS_CTRL, OFS_FLUSH: wr_ok = 1'b1;
            default:             wr_ok = 1'b0;
        endcase
    end

    assign legal = (!rd || rd_ok) && (!wr || wr_ok);
    assign wr_en = hit && wr && legal && (reg_off == OFS_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= 1'b0;
        end else if (wr_en) begin
            ctrl_q <= wdata[0];
        end
    end

    // Configuration word: present-core mask and count-1
    always_comb begin
        cfg_word = '0;
        cfg_word[CPU_W-1:0] = CPU_W'(cpu_count - 1'b1);
    end

    logic [MAX_CPU-1:0] present;
    for (genvar gi = 0; gi < MAX_CPU; gi++) begin : g_present
        assign present[gi] = (gi < int'(cpu_count));
    end

    always_comb begin
        unique case (reg_off)
            OFS_CTRL: rdata = DATA_W'(ctrl_q);
            OFS_CFG:  rdata = cfg_word | (DATA_W'(present) << CFG_MASK_LSB);
            default:  rdata = '0;
        endcase
    end

    // R3
    // ctrl_hold_chk
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> $past(hit && wr && reg_off == OFS_CTRL));

endmodule

// File: rtl/ppw_decoder.sv
module ppw_decoder
    import ppw_pkg::*;
#(
    parameter int MAX_CPU = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 32,
    parameter int CPU_W   = $clog2(MAX_CPU),
    parameter int SLOT_W  = CPU_W + 1,
    parameter int LOC_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [CPU_W:0]    cpu_count,
    output logic              rsp_valid,
    output logic              rsp_rd,
    output logic              rsp_wr,
    output logic [DATA_W-1:0] rsp_wdata,
    output logic              sel_local,
    output logic              sel_intf,
    output logic              sel_timer,
    output logic [SLOT_W-1:0] rsp_slot,
    output logic [LOC_W-1:0]  rsp_loc,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);

    logic [WIN_W-1:0]  off;
    ppw_region_e       region;
    logic              in_count;
    logic [SLOT_W-1:0] dec_slot;
    logic [LOC_W-1:0]  dec_loc;
    logic              local_legal;
    logic [DATA_W-1:0] local_rdata;
    logic              any_req;

    ppw_state_e        state_q, state_d;
    logic              cap_timer;
    logic [SLOT_W-1:0] cap_slot;
    logic [LOC_W-1:0]  cap_loc;
    logic              cap_rd;
    logic              cap_wr;
    logic [DATA_W-1:0] cap_wdata;
    logic [DATA_W-1:0] cap_rdata;

    assign off     = req_addr[WIN_W-1:0];
    assign any_req = req_rd || req_wr;

    ppw_window_decode #(
        .CPU_W  (CPU_W),
        .SLOT_W (SLOT_W),
        .LOC_W  (LOC_W)
    ) u_decode (
        .off       (off),
        .req_cpu   (req_cpu),
        .cpu_count (cpu_count),
        .region    (region),
        .in_count  (in_count),
        .slot      (dec_slot),
        .loc       (dec_loc)
    );

    ppw_ctrl_regs #(
        .MAX_CPU (MAX_CPU),
        .CPU_W   (CPU_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (region == RG_LOCAL),
        .rd        (req_rd),
        .wr        (req_wr),
        .reg_off   (off[7:0]),
        .wdata     (req_wdata),
        .cpu_count (cpu_count),
        .legal     (local_legal),
        .rdata     (local_rdata)
    );

    // Next-state selection
    always_comb begin
        state_d = ST_IDLE;
        if (any_req) begin
            unique case (region)
                RG_LOCAL:          state_d = local_legal ? ST_LOCAL : ST_FAULT;
                RG_INTF, RG_TIMER: state_d = in_count ? ST_ROUTE : ST_MUTE;
                default:           state_d = ST_FAULT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Access capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_timer <= 1'b0;
            cap_slot  <= '0;
            cap_loc   <= '0;
            cap_rd    <= 1'b0;
            cap_wr    <= 1'b0;
            cap_wdata <= '0;
            cap_rdata <= '0;
        end else if (any_req) begin
            cap_timer <= (region == RG_TIMER);
            cap_slot  <= dec_slot;
            cap_loc   <= dec_loc;
            cap_rd    <= req_rd;
            cap_wr    <= req_wr;
            cap_wdata <= req_wdata;
            cap_rdata <= req_rd ? local_rdata : '0;
        end
    end

    // Outputs from state
    always_comb begin
        rsp_valid = 1'b0;
        rsp_rd    = 1'b0;
        rsp_wr    = 1'b0;
        rsp_wdata = '0;
        sel_local = 1'b0;
        sel_intf  = 1'b0;
        sel_timer = 1'b0;
        rsp_slot  = '0;
        rsp_loc   = '0;
        rsp_rdata = '0;
        rsp_err   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ROUTE: begin
                rsp_valid = 1'b1;
                rsp_rd    = cap_rd;
                rsp_wr    = cap_wr;
                rsp_wdata = cap_wdata;
                sel_intf  = !cap_timer;
                sel_timer = cap_timer;
                rsp_slot  = cap_slot;
                rsp_loc   = cap_loc;
            end
            ST_LOCAL: begin
                rsp_valid = 1'b1;
                rsp_rd    = cap_rd;
                rsp_wr    = cap_wr;
                rsp_wdata = cap_wdata;
                sel_local = 1'b1;
                rsp_loc   = cap_loc;
                rsp_rdata = cap_rdata;
            end
            ST_MUTE: begin
                rsp_valid = 1'b1;
            end
            ST_FAULT: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: ;
        endcase
    end

    // R2
    // rsp_follows_req_chk
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd || req_wr) |=> rsp_valid);

    // R2
    // rsp_no_spurious_chk
    rsp_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_rd || req_wr));

    // R14
    // sel_onehot_chk
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_local, sel_intf, sel_timer}));

    // R6
    // err_isolated_chk
    err_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (!sel_local && !sel_intf && !sel_timer && rsp_rdata == '0));

    // R11
    // slot_in_count_chk
    slot_in_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_intf |-> (int'(rsp_slot) < int'($past(cpu_count))));

endmodule

// File: tb/ppw_decoder_tb.sv
module ppw_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_rd = 1'b0;
    logic        req_wr = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  req_cpu = '0;
    logic [2:0]  cpu_count = 3'd4;
    logic        rsp_valid, rsp_rd, rsp_wr;
    logic [31:0] rsp_wdata;
    logic        sel_local, sel_intf, sel_timer;
    logic [2:0]  rsp_slot;
    logic [7:0]  rsp_loc;
    logic [31:0] rsp_rdata;
    logic        rsp_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ppw_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_cpu(req_cpu),
        .cpu_count(cpu_count), .rsp_valid(rsp_valid), .rsp_rd(rsp_rd),
        .rsp_wr(rsp_wr), .rsp_wdata(rsp_wdata), .sel_local(sel_local),
        .sel_intf(sel_intf), .sel_timer(sel_timer), .rsp_slot(rsp_slot),
        .rsp_loc(rsp_loc), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    // One access; outputs are sampled at the next falling edge
    task automatic access(input logic rd, input logic wr, input logic [31:0] addr,
                          input logic [31:0] wd, input logic [1:0] cpu);
        @(negedge clk);
        req_rd = rd; req_wr = wr; req_addr = addr; req_wdata = wd; req_cpu = cpu;
        @(negedge clk);
        req_rd = 1'b0; req_wr = 1'b0;
    endtask

    function automatic logic [31:0] sels();
        return {29'd0, sel_local, sel_intf, sel_timer};
    endfunction

    task automatic t_reset();
        chk("R2 reset valid", 32'(rsp_valid), 0);
        chk("R2 reset err", 32'(rsp_err), 0);
        chk("R14 reset sels", sels(), 0);
        access(1, 0, 32'h0, 0, 0);
        chk("R3 ctrl reset read", rsp_rdata, 0);
        chk("R3 ctrl sel_local", sels(), 32'h4);
    endtask

    task automatic t_config();
        cpu_count = 3'd4; access(1, 0, 32'h4, 0, 0);
        chk("R4 cfg count4", rsp_rdata, 32'hF3);
        cpu_count = 3'd2; access(1, 0, 32'h4, 0, 0);
        chk("R4 cfg count2", rsp_rdata, 32'h31);
        cpu_count = 3'd1; access(1, 0, 32'h4, 0, 0);
        chk("R4 cfg count1", rsp_rdata, 32'h10);
        cpu_count = 3'd4;
        access(1, 0, 32'hABCD_E004, 0, 0);
        chk("R1 high bits ignored cfg", rsp_rdata, 32'hF3);
        chk("R1 high bits no err", 32'(rsp_err), 0);
    endtask

    task automatic t_ctrl();
        access(0, 1, 32'h0, 32'hFFFF_FFFF, 0);
        chk("R3 write no err", 32'(rsp_err), 0);
        chk("R14 local write fwd", 32'(rsp_wr), 1);
        access(1, 0, 32'h0, 0, 0);
        chk("R3 ctrl bit0 only", rsp_rdata, 32'h1);
        access(0, 1, 32'h0, 32'hFFFF_FFFE, 0);
        access(1, 0, 32'h0, 0, 0);
        chk("R3 ctrl cleared", rsp_rdata, 0);
    endtask

    task automatic t_status_flush();
        access(0, 1, 32'h0, 32'h1, 0);
        access(1, 0, 32'h8, 0, 0);
        chk("R5 status zero", rsp_rdata, 0);
        access(1, 0, 32'hC, 0, 0);
        chk("R5 flush read zero", rsp_rdata, 0);
        access(0, 1, 32'hC, 32'h0, 0);
        chk("R5 flush write no err", 32'(rsp_err), 0);
        access(1, 0, 32'h0, 0, 0);
        chk("R5 flush leaves ctrl", rsp_rdata, 1);
    endtask

    task automatic t_local_fault();
        access(1, 0, 32'h10, 0, 0);
        chk("R6 undefined read err", 32'(rsp_err), 1);
        chk("R6 undefined no sel", sels(), 0);
        chk("R6 undefined rdata", rsp_rdata, 0);
        @(negedge clk);
        chk("R6 err one cycle", 32'(rsp_err), 0);
        access(0, 1, 32'h4, 32'h0, 0);
        chk("R6 cfg write err", 32'(rsp_err), 1);
        access(0, 1, 32'h8, 32'h0, 0);
        chk("R6 status write err", 32'(rsp_err), 1);
        access(0, 1, 32'h2, 32'h0, 0);
        chk("R6 unaligned write err", 32'(rsp_err), 1);
        access(1, 0, 32'h0, 0, 0);
        chk("R6 fault keeps ctrl", rsp_rdata, 1);
    endtask

    task automatic t_intf();
        cpu_count = 3'd4;
        access(1, 0, 32'h134, 0, 2);
        chk("R7 alias sel", sels(), 32'h2);
        chk("R7 alias slot", 32'(rsp_slot), 2);
        chk("R7 alias loc", 32'(rsp_loc), 32'h34);
        access(0, 1, 32'h3A8, 32'h5A5A, 0);
        chk("R8 bank sel", sels(), 32'h2);
        chk("R8 bank slot", 32'(rsp_slot), 1);
        chk("R8 bank loc", 32'(rsp_loc), 32'hA8);
        chk("R14 fwd wr", 32'(rsp_wr), 1);
        chk("R14 fwd wdata", rsp_wdata, 32'h5A5A);
        access(1, 0, 32'h5FC, 0, 0);
        chk("R8 last bank slot", 32'(rsp_slot), 3);
    endtask

    task automatic t_timer();
        access(1, 0, 32'h620, 0, 3);
        chk("R9 alias wd slot", 32'(rsp_slot), 7);
        chk("R9 alias sel", sels(), 32'h1);
        chk("R9 alias loc", 32'(rsp_loc), 0);
        access(1, 0, 32'h60C, 0, 3);
        chk("R9 alias timer slot", 32'(rsp_slot), 6);
        chk("R9 alias timer loc", 32'(rsp_loc), 32'hC);
        access(1, 0, 32'h62C, 0, 1);
        chk("R9 loc low nibble", 32'(rsp_loc), 32'hC);
        chk("R9 slot cpu1 wd", 32'(rsp_slot), 3);
        access(0, 1, 32'h924, 32'h7, 0);
        chk("R10 bank slot", 32'(rsp_slot), 5);
        chk("R10 bank loc", 32'(rsp_loc), 4);
        access(1, 0, 32'h700, 0, 3);
        chk("R10 first bank slot", 32'(rsp_slot), 0);
    endtask

    task automatic t_mute();
        cpu_count = 3'd2;
        access(1, 0, 32'h400, 0, 0);
        chk("R11 intf bank muted valid", 32'(rsp_valid), 1);
        chk("R11 intf bank muted sels", sels(), 0);
        chk("R11 muted err", 32'(rsp_err), 0);
        access(0, 1, 32'hA00, 32'hFFFF, 0);
        chk("R11 timer bank muted sels", sels(), 0);
        chk("R11 muted no wr fwd", 32'(rsp_wr), 0);
        access(1, 0, 32'h620, 0, 3);
        chk("R11 alias high cpu muted", sels(), 0);
        chk("R11 alias muted rdata", rsp_rdata, 0);
        access(1, 0, 32'h820, 0, 0);
        chk("R11 in-count timer routed", sels(), 32'h1);
        chk("R11 in-count slot", 32'(rsp_slot), 3);
        cpu_count = 3'd4;
    endtask

    task automatic t_upper_fault();
        access(1, 0, 32'hB00, 0, 0);
        chk("R12 B00 err", 32'(rsp_err), 1);
        chk("R12 B00 no sel", sels(), 0);
        access(0, 1, 32'hFFF, 32'h1, 0);
        chk("R12 FFF err", 32'(rsp_err), 1);
        access(1, 0, 32'h1000_0AFC, 0, 0);
        chk("R1 high bits on AFC routes", sels(), 32'h1);
        chk("R12 AFC not err", 32'(rsp_err), 0);
    endtask

    task automatic t_both_strobes();
        access(0, 1, 32'h0, 32'h0, 0);
        access(1, 1, 32'h0, 32'h1, 0);
        chk("R13 old value read", rsp_rdata, 0);
        chk("R13 no err", 32'(rsp_err), 0);
        access(1, 0, 32'h0, 0, 0);
        chk("R13 write stored", rsp_rdata, 1);
        @(negedge clk);
        chk("R2 idle after access", 32'(rsp_valid), 0);
    endtask

    initial begin
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog R2 actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_ctrl();
        t_status_flush();
        t_local_fault();
        t_intf();
        t_timer();
        t_mute();
        t_upper_fault();
        t_both_strobes();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule